// File: doc/BRIEF.md
# Two-Phase Serial Audio Transmitter

This block turns parallel audio words into a single serial data line. Bit clock and frame sync are both inputs, and the block samples them in its own system clock domain. A frame holds a first phase and, if enabled, a second phase. Each phase has its own word length and its own word count. After an active frame sync, the block waits 0, 1 or 2 bit clocks and then shifts the words out MSB first. The data line is driven on the selected bit-clock edge and is held low whenever no word bit is on it.

Words arrive through a one-entry holding register with a ready/valid handshake. The register is drained at the start of every word slot. If it is empty at that moment, the previous word is sent again and a sticky underrun flag is raised. A frame sync that arrives while a frame is still in progress is either disregarded or reported as a sync error, depending on a configuration bit. A reported sync error also restarts the frame from that sync.

A transmitter reset input keeps the line quiet and clears the flags. The reset state changes only on a bit-clock transition. The holding register keeps its content through the transmitter reset, so a first word can be preloaded before starting.

Top module: `sat_tx`

## Requirements
- R1: Word-length code (cfg_wlen1_i / cfg_wlen2_i) maps 0→8, 1→12, 2→16, 3→20, 4→24 and 5→32 bits. Codes 6 and 7 also give 32 bits. A word is taken right-aligned from the data bus and sent MSB first: bit L-1 first, down to bit 0.
- R2: A frame is cfg_cnt1_i+1 words of phase-1 length. When cfg_phase2_en_i is 1, these are followed by cfg_cnt2_i+1 words of phase-2 length.
- R3: cfg_delay_i inserts 0, 1 or 2 low bit slots between the sync slot and the first data bit. Code 3 acts as 2. With delay 0, the MSB is driven in the sync slot itself.
- R4: With cfg_clk_fall_i=0, data is driven on rising bit-clock edges. With cfg_clk_fall_i=1, data is driven on falling edges. The frame sync is sampled on those same edges.
- R5: The frame sync is active high when cfg_fs_low_i=0 and active low when cfg_fs_low_i=1. A frame starts on a drive edge where the sync is active and was inactive at the previous drive edge.
- R6: sdata_o is low in every slot that carries no word bit: delay slots, and idle slots between frames.
- R7: wr_ready_o is 1 exactly when the holding register is empty. A word is accepted on a clock edge where wr_valid_i and wr_ready_o are both 1. The register empties at the start of the next word slot.
- R8: When a word slot starts with the holding register empty, the previous word is repeated and underrun_o goes to 1. It stays at 1 until the transmitter reset.
- R9: With cfg_fs_ignore_i=1, a sync start during a frame has no effect: the frame continues and sync_err_o stays 0.
- R10: With cfg_fs_ignore_i=0, a sync start during a frame sets sync_err_o, which then stays at 1. The frame restarts from that sync.
- R11: tx_run_o takes the value of the inverted tx_rst_i only on a clock edge that sees a bit-clock transition. While tx_run_o is 0, sdata_o is 0 and both flags are cleared.
- R12: Outputs are registered. With SYNC_STAGES=0, sdata_o changes on the system clock edge that first samples the new bit-clock level.
- R13: The holding register is independent of the transmitter reset. A word written during reset stays held, and wr_ready_o stays 0, until it is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| bclk_i | input | 1 | Bit clock |
| fsync_i | input | 1 | Frame sync |
| tx_rst_i | input | 1 | Transmitter reset request, active high |
| cfg_clk_fall_i | input | 1 | 1 selects falling-edge drive |
| cfg_fs_low_i | input | 1 | 1 selects active-low frame sync |
| cfg_fs_ignore_i | input | 1 | 1 disregards syncs that arrive during a frame |
| cfg_delay_i | input | 2 | Data delay in bit slots |
| cfg_phase2_en_i | input | 1 | Enables the second phase |
| cfg_wlen1_i | input | 3 | Phase-1 word-length code |
| cfg_wlen2_i | input | 3 | Phase-2 word-length code |
| cfg_cnt1_i | input | CNT_W | Phase-1 word count minus one |
| cfg_cnt2_i | input | CNT_W | Phase-2 word count minus one |
| wr_valid_i | input | 1 | Word offered |
| wr_data_i | input | DATA_W | Word, right-aligned |
| wr_ready_o | output | 1 | Holding register empty |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |
| sync_err_o | output | 1 | Sticky sync-error flag |
| tx_run_o | output | 1 | Transmitter out of reset |

## Verification
Every result has a fixed latency, so the bench can predict each one exactly:
- sdata_o, underrun_o and sync_err_o change on the same system clock edge that samples the driving bit-clock level.
- tx_run_o changes on the clock edge that samples any bit-clock toggle.
- wr_ready_o falls one edge after acceptance and rises one edge after a word-slot start.

The bench changes inputs on falling clock edges and steps a behavioural model on each rising edge using those same inputs. It then compares all five outputs with the model on the next falling edge, so every comparison lands after the edge on which a result is due. Targeted checks then confirm the flags and the preload after each scenario.

// File: rtl/sat_pkg.sv
package sat_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_DATA  = 2'd2
   } sat_state_e;

   // word-length code to number of bits; unused codes fall back to 32
   function automatic logic [5:0] wlen_bits(input logic [2:0] code);
      logic [5:0] n;
      case (code)
         3'd0:    n = 6'd8;
         3'd1:    n = 6'd12;
         3'd2:    n = 6'd16;
         3'd3:    n = 6'd20;
         3'd4:    n = 6'd24;
         default: n = 6'd32;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/sat_edge.sv
module sat_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic fsync_i,
   input  logic cfg_clk_fall_i,
   input  logic cfg_fs_low_i,
   output logic tick_o,
   output logic edge_o,
   output logic fs_act_o
);

   logic bclk_s;
   logic fs_s;
   logic bclk_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign bclk_s = bclk_i;
      assign fs_s   = fsync_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] bclk_chain;
      logic [SYNC_STAGES-1:0] fs_chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bclk_chain <= '0;
            fs_chain   <= '0;
         end else begin
            bclk_chain <= {bclk_chain[SYNC_STAGES-1:0] , bclk_i} >> 0;
            fs_chain   <= {fs_chain[SYNC_STAGES-1:0] , fsync_i} >> 0;
         end
      end
      assign bclk_s = bclk_chain[SYNC_STAGES-1];
      assign fs_s   = fs_chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk_s;
   end

   assign edge_o   = bclk_s ^ bclk_q;
   assign tick_o   = edge_o & (bclk_s ^ cfg_clk_fall_i);
   assign fs_act_o = fs_s ^ cfg_fs_low_i;

   // R4
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/sat_run_ctl.sv
module sat_run_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic tx_rst_i,
   output logic run_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_o <= 1'b0;
      else if (edge_i) run_o <= ~tx_rst_i;
   end

   // R11
   run_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_i |=> $stable(run_o));

endmodule

// File: rtl/sat_hold.sv
module sat_hold #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              take_i,
   output logic              ready_o,
   output logic              full_o,
   output logic [DATA_W-1:0] word_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_o <= 1'b0;
         word_o <= '0;
      end else if (full_o) begin
         if (take_i) full_o <= 1'b0;
      end else if (wr_valid_i) begin
         full_o <= 1'b1;
         word_o <= wr_data_i;
      end
   end

   assign ready_o = ~full_o;

   // R7
   held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_o && !take_i |=> full_o && $stable(word_o));

   // R7
   empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !full_o && !wr_valid_i |=> !full_o);

endmodule

// File: rtl/sat_framer.sv
module sat_framer
   import sat_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              fs_act_i,
   input  logic              run_i,
   input  logic              cfg_fs_ignore_i,
   input  logic [1:0]        cfg_delay_i,
   input  logic              cfg_phase2_en_i,
   input  logic [2:0]        cfg_wlen1_i,
   input  logic [2:0]        cfg_wlen2_i,
   input  logic [CNT_W-1:0]  cfg_cnt1_i,
   input  logic [CNT_W-1:0]  cfg_cnt2_i,
   input  logic              hold_full_i,
   input  logic [DATA_W-1:0] hold_word_i,
   output logic              take_o,
   output logic              sdata_o,
   output logic              underrun_o,
   output logic              sync_err_o
);

   localparam int BW    = $clog2(DATA_W + 1);
   localparam int IDX_W = $clog2(DATA_W);

   sat_state_e        state_q, state_d;
   logic              phase_q, phase_d;
   logic [CNT_W-1:0]  word_q, word_d;
   logic [BW-1:0]     bit_q, bit_d;
   logic [1:0]        dcnt_q, dcnt_d;
   logic [DATA_W-1:0] cur_q, cur_d;
   logic              fs_prev_q;

   logic              fs_start, last_in_phase, frame_end, busy;
   logic              accept_fs, mid_err;
   logic [1:0]        delay_eff;
   logic              begin_w, w_phase;
   logic [CNT_W-1:0]  w_idx;
   logic [BW-1:0]     wl;
   logic [DATA_W-1:0] word_src;
   logic [IDX_W-1:0]  rd_idx, st_idx;
   logic              out_bit;

   assign fs_start      = tick_i && fs_act_i && !fs_prev_q;
   assign last_in_phase = (word_q == (phase_q ? cfg_cnt2_i : cfg_cnt1_i));
   assign frame_end     = (state_q == ST_DATA) && (bit_q == '0) && last_in_phase
                          && (phase_q || !cfg_phase2_en_i);
   assign busy          = (state_q == ST_DELAY) || ((state_q == ST_DATA) && !frame_end);
   assign accept_fs     = fs_start && (!busy || !cfg_fs_ignore_i);
   assign mid_err       = fs_start && busy && !cfg_fs_ignore_i;
   assign delay_eff     = (cfg_delay_i == 2'd3) ? 2'd2 : cfg_delay_i;
   assign rd_idx        = IDX_W'(bit_q - BW'(1));

   always_comb begin
      state_d = state_q;
      phase_d = phase_q;
      word_d  = word_q;
      bit_d   = bit_q;
      dcnt_d  = dcnt_q;
      cur_d   = cur_q;
      begin_w = 1'b0;
      w_phase = phase_q;
      w_idx   = word_q;
      out_bit = 1'b0;
      if (accept_fs) begin
         if (delay_eff == 2'd0) begin
            begin_w = 1'b1;
            w_phase = 1'b0;
            w_idx   = '0;
         end else begin
            state_d = ST_DELAY;
            dcnt_d  = delay_eff - 2'd1;
         end
      end else begin
         case (state_q)
            ST_DELAY: begin
               if (dcnt_q == 2'd0) begin
                  begin_w = 1'b1;
                  w_phase = 1'b0;
                  w_idx   = '0;
               end else begin
                  dcnt_d = dcnt_q - 2'd1;
               end
            end
            ST_DATA: begin
               if (bit_q != '0) begin
                  bit_d   = bit_q - BW'(1);
                  out_bit = cur_q[rd_idx];
               end else if (!last_in_phase) begin
                  begin_w = 1'b1;
                  w_idx   = word_q + 1'b1;
               end else if (!phase_q && cfg_phase2_en_i) begin
                  begin_w = 1'b1;
                  w_phase = 1'b1;
                  w_idx   = '0;
               end else begin
                  state_d = ST_IDLE;
               end
            end
            default: state_d = ST_IDLE;
         endcase
      end
      wl       = BW'(wlen_bits(w_phase ? cfg_wlen2_i : cfg_wlen1_i));
      word_src = hold_full_i ? hold_word_i : cur_q;
      st_idx   = IDX_W'(wl - BW'(1));
      if (begin_w) begin
         state_d = ST_DATA;
         phase_d = w_phase;
         word_d  = w_idx;
         bit_d   = wl - BW'(1);
         cur_d   = word_src;
         out_bit = word_src[st_idx];
      end
   end

   assign take_o = tick_i && run_i && begin_w && hold_full_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= 1'b0;
         word_q     <= '0;
         bit_q      <= '0;
         dcnt_q     <= '0;
         cur_q      <= '0;
         fs_prev_q  <= 1'b0;
         sdata_o    <= 1'b0;
         underrun_o <= 1'b0;
         sync_err_o <= 1'b0;
      end else begin
         if (tick_i) fs_prev_q <= fs_act_i;
         if (!run_i) begin
            state_q    <= ST_IDLE;
            phase_q    <= 1'b0;
            word_q     <= '0;
            bit_q      <= '0;
            dcnt_q     <= '0;
            sdata_o    <= 1'b0;
            underrun_o <= 1'b0;
            sync_err_o <= 1'b0;
         end else if (tick_i) begin
            state_q <= state_d;
            phase_q <= phase_d;
            word_q  <= word_d;
            bit_q   <= bit_d;
            dcnt_q  <= dcnt_d;
            cur_q   <= cur_d;
            sdata_o <= out_bit;
            if (begin_w && !hold_full_i) underrun_o <= 1'b1;
            if (mid_err)                 sync_err_o <= 1'b1;
         end
      end
   end

   // R11
   quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !sdata_o);

   // R12
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i && !tick_i |=> $stable(sdata_o));

   // R8
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i && underrun_o |=> underrun_o);

   // R9
   ignore_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i && cfg_fs_ignore_i && !sync_err_o |=> !sync_err_o);

   // R3
   delay_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_DELAY |-> !sdata_o);

endmodule

// File: rtl/sat_tx.sv
module sat_tx #(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_i,
   input  logic              fsync_i,
   input  logic              tx_rst_i,
   input  logic              cfg_clk_fall_i,
   input  logic              cfg_fs_low_i,
   input  logic              cfg_fs_ignore_i,
   input  logic [1:0]        cfg_delay_i,
   input  logic              cfg_phase2_en_i,
   input  logic [2:0]        cfg_wlen1_i,
   input  logic [2:0]        cfg_wlen2_i,
   input  logic [CNT_W-1:0]  cfg_cnt1_i,
   input  logic [CNT_W-1:0]  cfg_cnt2_i,
   input  logic              wr_valid_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              wr_ready_o,
   output logic              sdata_o,
   output logic              underrun_o,
   output logic              sync_err_o,
   output logic              tx_run_o
);

   if (DATA_W < 32) begin : g_bad_dw
      $error("sat_tx: DATA_W must hold a 32-bit word");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("sat_tx: CNT_W must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("sat_tx: SYNC_STAGES must be 0 to 3");
   end

   logic              tick, bedge, fs_act;
   logic              take, hold_full;
   logic [DATA_W-1:0] hold_word;

   sat_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk            (clk),
      .rst_n          (rst_n),
      .bclk_i         (bclk_i),
      .fsync_i        (fsync_i),
      .cfg_clk_fall_i (cfg_clk_fall_i),
      .cfg_fs_low_i   (cfg_fs_low_i),
      .tick_o         (tick),
      .edge_o         (bedge),
      .fs_act_o       (fs_act)
   );

   sat_run_ctl u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_i   (bedge),
      .tx_rst_i (tx_rst_i),
      .run_o    (tx_run_o)
   );

   sat_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid_i (wr_valid_i),
      .wr_data_i  (wr_data_i),
      .take_i     (take),
      .ready_o    (wr_ready_o),
      .full_o     (hold_full),
      .word_o     (hold_word)
   );

   sat_framer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_framer (
      .clk             (clk),
      .rst_n           (rst_n),
      .tick_i          (tick),
      .fs_act_i        (fs_act),
      .run_i           (tx_run_o),
      .cfg_fs_ignore_i (cfg_fs_ignore_i),
      .cfg_delay_i     (cfg_delay_i),
      .cfg_phase2_en_i (cfg_phase2_en_i),
      .cfg_wlen1_i     (cfg_wlen1_i),
      .cfg_wlen2_i     (cfg_wlen2_i),
      .cfg_cnt1_i      (cfg_cnt1_i),
      .cfg_cnt2_i      (cfg_cnt2_i),
      .hold_full_i     (hold_full),
      .hold_word_i     (hold_word),
      .take_o          (take),
      .sdata_o         (sdata_o),
      .underrun_o      (underrun_o),
      .sync_err_o      (sync_err_o)
   );

   // R13
   preload_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_run_o && !wr_ready_o |=> !wr_ready_o);

endmodule

// File: tb/sat_tx_bench.sv
`timescale 1ns/100ps
module sat_tx_bench;

   localparam int DATA_W = 32;
   localparam int CNT_W  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0;
   logic fsync = 1'b0;
   logic tx_rst = 1'b1;
   logic cfg_clk_fall = 1'b0, cfg_fs_low = 1'b0, cfg_fs_ignore = 1'b0;
   logic [1:0] cfg_delay = 2'd1;
   logic cfg_ph2 = 1'b1;
   logic [2:0] cfg_wlen1 = 3'd2, cfg_wlen2 = 3'd2;
   logic [CNT_W-1:0] cfg_cnt1 = '0, cfg_cnt2 = '0;
   logic wr_valid = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic wr_ready, sdata, underrun, sync_err, tx_run;

   always #2.5 clk = ~clk;

   sat_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sat_tx (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .tx_rst_i(tx_rst),
      .cfg_clk_fall_i(cfg_clk_fall), .cfg_fs_low_i(cfg_fs_low),
      .cfg_fs_ignore_i(cfg_fs_ignore), .cfg_delay_i(cfg_delay),
      .cfg_phase2_en_i(cfg_ph2), .cfg_wlen1_i(cfg_wlen1), .cfg_wlen2_i(cfg_wlen2),
      .cfg_cnt1_i(cfg_cnt1), .cfg_cnt2_i(cfg_cnt2),
      .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
      .sdata_o(sdata), .underrun_o(underrun), .sync_err_o(sync_err), .tx_run_o(tx_run)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit chk_en = 0;
   string tag = "R1 R2 R3 R4 R5 R6 R12";

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int   q[$];
   bit   m_bq, m_run, m_fsprev, m_sd, m_ur, m_se, m_full;
   logic [31:0] m_hold, m_cur;
   bit   b_old, tk, edg, fsa, fss, run_old, full_pre;
   int   item, ln, bi;

   function automatic int len_of(input logic [2:0] c);
      case (c)
         3'd0: return 8;
         3'd1: return 12;
         3'd2: return 16;
         3'd3: return 20;
         3'd4: return 24;
         default: return 32;
      endcase
   endfunction

   task automatic build_frame();
      int d;
      q.delete();
      d = (cfg_delay == 2'd3) ? 2 : int'(cfg_delay);
      for (int k = 0; k < d; k++) q.push_back(-1);
      for (int w = 0; w <= int'(cfg_cnt1); w++)
         for (int b = len_of(cfg_wlen1) - 1; b >= 0; b--) q.push_back(len_of(cfg_wlen1) * 64 + b);
      if (cfg_ph2)
         for (int w = 0; w <= int'(cfg_cnt2); w++)
            for (int b = len_of(cfg_wlen2) - 1; b >= 0; b--) q.push_back(len_of(cfg_wlen2) * 64 + b);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_bq = 0; m_run = 0; m_fsprev = 0; m_sd = 0; m_ur = 0; m_se = 0;
         m_full = 0; m_hold = '0; m_cur = '0;
      end else begin
         b_old = m_bq;
         m_bq = bclk;
         edg = (bclk != b_old);
         tk = edg && (bclk != cfg_clk_fall);
         fsa = fsync ^ cfg_fs_low;
         run_old = m_run;
         full_pre = m_full;
         if (tk) begin
            fss = fsa && !m_fsprev;
            m_fsprev = fsa;
         end else fss = 0;
         if (!run_old) begin
            q.delete();
            m_sd = 0; m_ur = 0; m_se = 0;
         end else if (tk) begin
            if (fss) begin
               if (q.size() == 0) build_frame();
               else if (!cfg_fs_ignore) begin
                  m_se = 1;
                  build_frame();
               end
            end
            if (q.size() == 0) m_sd = 0;
            else begin
               item = q.pop_front();
               if (item < 0) m_sd = 0;
               else begin
                  ln = item / 64;
                  bi = item % 64;
                  if (bi == ln - 1) begin
                     if (full_pre) begin
                        m_cur = m_hold;
                        m_full = 0;
                     end else m_ur = 1;
                  end
                  m_sd = m_cur[bi];
               end
            end
         end
         if (wr_valid && !full_pre) begin
            m_hold = wr_data;
            m_full = 1;
         end
         if (edg) m_run = !tx_rst;
      end
   end

   always @(negedge clk) begin
      if (rst_n && chk_en && !done) begin
         check(sdata == m_sd, tag, "sdata", sdata, m_sd);
         check(wr_ready == !m_full, "R7", "wr_ready", wr_ready, !m_full);
         check(underrun == m_ur, "R8", "underrun", underrun, m_ur);
         check(sync_err == m_se, "R10", "sync_err", sync_err, m_se);
         check(tx_run == m_run, "R11", "tx_run", tx_run, m_run);
      end
   end

   // ---------------- bit clock and frame sync ----------------
   int period = 40;
   int pos = 0;
   bit fs_en = 0;
   bit inject = 0;

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         bclk = ~bclk;
         if (bclk != cfg_clk_fall) begin
            fsync = (fs_en && (pos == 0 || inject)) ^ cfg_fs_low;
            inject = 0;
            pos = (pos + 1 >= period) ? 0 : pos + 1;
         end
      end
   end

   // ---------------- word feeder ----------------
   bit feed_en = 0;
   bit rdy_prev = 0;
   logic [31:0] lcg = 32'h1234_5678;

   always @(negedge clk) begin
      if (rst_n) begin
         if ((wr_valid && rdy_prev) || !wr_valid) begin
            if (feed_en) begin
               lcg = lcg * 32'd1103515245 + 32'd12345;
               wr_data = lcg;
               wr_valid = 1'b1;
            end else wr_valid = 1'b0;
         end
         if (!feed_en) wr_valid = 1'b0;
         rdy_prev = wr_ready;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_sim();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R12 watchdog expired actual=0 expected=1");
         finish_sim();
      end
   end

   initial begin
      wait_clk(4);
      // reset state
      check(wr_ready == 1'b1, "R7", "reset wr_ready", wr_ready, 1);
      check(sdata == 1'b0, "R6", "reset sdata", sdata, 0);
      check(underrun == 1'b0, "R8", "reset underrun", underrun, 0);
      check(sync_err == 1'b0, "R10", "reset sync_err", sync_err, 0);
      check(tx_run == 1'b0, "R11", "reset tx_run", tx_run, 0);
      rst_n = 1'b1;
      chk_en = 1;

      // preload during transmitter reset
      feed_en = 1;
      wait_clk(20);
      check(wr_ready == 1'b0, "R13", "preload held in reset", wr_ready, 0);
      check(tx_run == 1'b0, "R13", "still in reset", tx_run, 0);

      // A: rising edge, active-high sync, delay 1, 16+16
      tag = "R1 R2 R3 R5 R6 R12";
      fs_en = 1;
      tx_rst = 1'b0;
      wait_clk(40 * 6 * 8);
      check(underrun == 1'b0, "R7", "no underrun when fed", underrun, 0);
      check(sync_err == 1'b0, "R5", "no sync error A", sync_err, 0);
      tx_rst = 1'b1;
      wait_clk(20);
      check(tx_run == 1'b0, "R11", "run dropped", tx_run, 0);
      check(sdata == 1'b0, "R11", "line quiet in reset", sdata, 0);

      // B: falling edge, active-low sync, delay 0, 2x8 then 3x24
      tag = "R1 R2 R3 R4 R5";
      cfg_clk_fall = 1'b1; cfg_fs_low = 1'b1; cfg_delay = 2'd0;
      cfg_wlen1 = 3'd0; cfg_cnt1 = 6'd1; cfg_wlen2 = 3'd4; cfg_cnt2 = 6'd2;
      period = 90;
      wait_clk(20);
      tx_rst = 1'b0;
      wait_clk(90 * 6 * 5);
      check(sync_err == 1'b0, "R4", "no sync error B", sync_err, 0);
      tx_rst = 1'b1;
      wait_clk(20);

      // C: delay 2, 2x12 then 1x32
      tag = "R1 R3 R6";
      cfg_clk_fall = 1'b0; cfg_fs_low = 1'b0; cfg_delay = 2'd2;
      cfg_wlen1 = 3'd1; cfg_cnt1 = 6'd1; cfg_wlen2 = 3'd5; cfg_cnt2 = 6'd0;
      period = 60;
      wait_clk(20);
      tx_rst = 1'b0;
      wait_clk(60 * 6 * 5);
      tx_rst = 1'b1;
      wait_clk(20);

      // C2: reserved length code 7 and delay code 3
      tag = "R1 R3";
      cfg_wlen2 = 3'd7; cfg_delay = 2'd3;
      tx_rst = 1'b0;
      wait_clk(60 * 6 * 4);
      tx_rst = 1'b1;
      wait_clk(20);

      // D: single phase, 3x20
      tag = "R2 R6";
      cfg_ph2 = 1'b0; cfg_wlen1 = 3'd3; cfg_cnt1 = 6'd2;
      period = 64;
      tx_rst = 1'b0;
      wait_clk(64 * 6 * 4);
      check(underrun == 1'b0, "R8", "no underrun before starve", underrun, 0);

      // underrun: stop feeding
      tag = "R8";
      feed_en = 0;
      wait_clk(64 * 6 * 3);
      check(underrun == 1'b1, "R8", "underrun raised", underrun, 1);
      feed_en = 1;
      wait_clk(64 * 6 * 2);
      check(underrun == 1'b1, "R8", "underrun sticky", underrun, 1);

      // mid-frame sync ignored
      tag = "R9";
      cfg_fs_ignore = 1'b1;
      wait (pos == 10);
      inject = 1;
      wait_clk(64 * 6 * 2);
      check(sync_err == 1'b0, "R9", "ignored sync", sync_err, 0);

      // mid-frame sync reported
      tag = "R10";
      cfg_fs_ignore = 1'b0;
      wait (pos == 10);
      inject = 1;
      wait_clk(64 * 6);
      check(sync_err == 1'b1, "R10", "sync error raised", sync_err, 1);
      wait_clk(64 * 6);
      check(sync_err == 1'b1, "R10", "sync error sticky", sync_err, 1);

      // transmitter reset clears flags
      tx_rst = 1'b1;
      wait_clk(20);
      check(underrun == 1'b0, "R11", "underrun cleared", underrun, 0);
      check(sync_err == 1'b0, "R11", "sync_err cleared", sync_err, 0);
      check(tx_run == 1'b0, "R11", "run low", tx_run, 0);

      finish_sim();
   end

endmodule